// File: doc/BRIEF.md
# Receive-Only Byte Request Controller

This block drives receive-only transfers for an SPI master. Software writes a byte count, and the controller asks the serializer for shift clocks, with no transmit data involved, until that many bytes have arrived. It ignores any configured word length. Incoming bytes are packed four to a 32-bit receive FIFO entry. The earliest byte of a full entry lands in the top byte.

When the count runs out and a word is only partly filled, that word is still written. Its bytes are right-aligned, and its earliest byte sits at bit offset (valid-1)*8. A 3-bit valid-byte field reports how many bytes the most recent entry holds, and a 16-bit to-do count shows how many requested bytes are still outstanding. Clocking stops while the FIFO reports full, so no entry is ever lost. The write of the last entry is marked with a one-cycle done pulse.

Top module: `rxo_recv_ctrl`

## Requirements
- R1: After reset, todo_o is 0, bval_o is 0, and sclk_en_o, fifo_wr_o and done_o are low.
- R2: A write of request count N>0 while idle sets todo_o to N at the next clock edge. sclk_en_o is high exactly when todo_o is non-zero and fifo_full_i is low.
- R3: Each rx_vld_i cycle with todo_o non-zero lowers todo_o by one. A byte offered while todo_o is 0 changes nothing and is not written.
- R4: Every four consecutive received bytes form one 32-bit FIFO entry. The first byte goes to bits 31:24 and the fourth to bits 7:0, independent of any word-length setting.
- R5: A final entry with k=1..3 bytes holds them in the low k bytes with the earliest byte at bits (k-1)*8+7:(k-1)*8, and its unused upper bytes are zero.
- R6: bval_o gives the number of valid bytes (1 to 4) of the entry being or last written to the FIFO.
- R7: While fifo_full_i is high, sclk_en_o and fifo_wr_o are low. A completed entry waits and is written once space frees, with no entry lost or duplicated.
- R8: done_o pulses for one cycle together with the FIFO write of the entry that holds the last requested byte, and is low otherwise.
- R9: A request written while todo_o is non-zero adds to the remaining count instead of replacing it, saturating at 65535.
- R10: A request write with a count of 0 leaves todo_o and sclk_en_o unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_wr_i | input | 1 | Request count write strobe |
| req_cnt_i | input | 16 | Number of bytes to receive |
| todo_o | output | 16 | Requested bytes not yet received |
| bval_o | output | 3 | Valid bytes in the latest FIFO entry |
| sclk_en_o | output | 1 | Shift clock enable toward the serializer |
| rx_vld_i | input | 1 | Serializer delivers a byte this cycle |
| rx_byte_i | input | 8 | Received byte |
| fifo_full_i | input | 1 | Receive FIFO has no free entry |
| fifo_wr_o | output | 1 | FIFO write strobe |
| fifo_wdata_o | output | 32 | FIFO write data |
| done_o | output | 1 | Last entry of the request written |

## Verification
On every cycle, the assertions check:
- no write or shift clock while the FIFO is full;
- no clocking with a zero count;
- the one-step decrement and additive, non-saturating request updates;
- that a zero-count write is ignored;
- the range of the valid-byte field;
- that done only accompanies a write.

Only the bench scenarios can show:
- the byte ordering inside full and partial entries;
- that a held entry comes out exactly once after back-pressure;
- that done marks the right entry;
- saturation of the count when a request is added to an active transfer.

// File: rtl/rxo_pkg.sv
package rxo_pkg;
  parameter int unsigned RXO_DATA_W = 32;
  parameter int unsigned RXO_BYTE_W = 8;
  parameter int unsigned RXO_CNT_W  = 16;
endpackage

// File: rtl/rxo_req_cnt.sv
module rxo_req_cnt #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_wr_i,
  input  logic [CNT_W-1:0] req_cnt_i,
  input  logic             take_i,
  output logic [CNT_W-1:0] todo_o,
  output logic             active_o,
  output logic             final_o
);
  logic [CNT_W-1:0] todo_q;
  logic [CNT_W:0]   sum;
  logic [CNT_W:0]   add;
  logic [CNT_W-1:0] todo_d;

  always_comb begin
    add    = req_wr_i ? {1'b0, req_cnt_i} : '0;
    sum    = {1'b0, todo_q} + add - {{CNT_W{1'b0}}, take_i};
    todo_d = sum[CNT_W] ? {CNT_W{1'b1}} : sum[CNT_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) todo_q <= '0;
    else         todo_q <= todo_d;
  end

  assign active_o = (todo_q != '0);
  // last byte only if no fresh count arrives with it
  assign final_o  = take_i && (todo_q == CNT_W'(1)) && !(req_wr_i && (req_cnt_i != '0));
  assign todo_o   = todo_q;
endmodule

// File: rtl/rxo_byte_packer.sv
module rxo_byte_packer #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned BV_W   = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              take_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              flush_i,
  output logic              word_vld_o,
  output logic [DATA_W-1:0] word_o,
  output logic [BV_W-1:0]   word_bytes_o,
  output logic              word_last_o
);
  localparam int unsigned BPW = DATA_W / BYTE_W;

  logic [DATA_W-1:0] acc_q;
  logic [BV_W-1:0]   fill_q;
  logic [DATA_W-1:0] shifted;
  logic [BV_W-1:0]   fill_n;

  always_comb begin
    shifted = {acc_q[DATA_W-BYTE_W-1:0], byte_i};
    fill_n  = fill_q + BV_W'(1);
  end

  assign word_vld_o   = take_i && ((fill_n == BV_W'(BPW)) || flush_i);
  assign word_o       = shifted;
  assign word_bytes_o = fill_n;
  assign word_last_o  = flush_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q  <= '0;
      fill_q <= '0;
    end else if (take_i) begin
      if (word_vld_o) begin
        acc_q  <= '0;
        fill_q <= '0;
      end else begin
        acc_q  <= shifted;
        fill_q <= fill_n;
      end
    end
  end
endmodule

// File: rtl/rxo_push_stage.sv
module rxo_push_stage #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned BV_W   = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              word_vld_i,
  input  logic [DATA_W-1:0] word_i,
  input  logic [BV_W-1:0]   word_bytes_i,
  input  logic              word_last_i,
  input  logic              fifo_full_i,
  output logic              fifo_wr_o,
  output logic [DATA_W-1:0] fifo_wdata_o,
  output logic [BV_W-1:0]   bval_o,
  output logic              done_o,
  output logic              pend_o
);
  logic              pend_q;
  logic              last_q;
  logic [DATA_W-1:0] data_q;
  logic [BV_W-1:0]   bytes_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q  <= 1'b0;
      last_q  <= 1'b0;
      data_q  <= '0;
      bytes_q <= '0;
    end else begin
      pend_q <= word_vld_i || (pend_q && fifo_full_i);
      if (word_vld_i) begin
        data_q  <= word_i;
        bytes_q <= word_bytes_i;
        last_q  <= word_last_i;
      end
    end
  end

  assign fifo_wr_o    = pend_q && !fifo_full_i;
  assign fifo_wdata_o = data_q;
  assign bval_o       = bytes_q;
  assign done_o       = fifo_wr_o && last_q;
  assign pend_o       = pend_q;
endmodule

// File: rtl/rxo_recv_ctrl.sv
module rxo_recv_ctrl
  import rxo_pkg::*;
#(
  parameter int unsigned DATA_W = RXO_DATA_W,
  parameter int unsigned BYTE_W = RXO_BYTE_W,
  parameter int unsigned CNT_W  = RXO_CNT_W,
  parameter int unsigned BV_W   = $clog2(DATA_W / BYTE_W + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_wr_i,
  input  logic [CNT_W-1:0]  req_cnt_i,
  output logic [CNT_W-1:0]  todo_o,
  output logic [BV_W-1:0]   bval_o,
  output logic              sclk_en_o,
  input  logic              rx_vld_i,
  input  logic [BYTE_W-1:0] rx_byte_i,
  input  logic              fifo_full_i,
  output logic              fifo_wr_o,
  output logic [DATA_W-1:0] fifo_wdata_o,
  output logic              done_o
);
  logic              active;
  logic              take;
  logic              final_byte;
  logic              word_vld;
  logic [DATA_W-1:0] word;
  logic [BV_W-1:0]   word_bytes;
  logic              word_last;
  logic              pend;

  assign take      = rx_vld_i && active;
  assign sclk_en_o = active && !fifo_full_i;

  rxo_req_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_wr_i  (req_wr_i),
    .req_cnt_i (req_cnt_i),
    .take_i    (take),
    .todo_o    (todo_o),
    .active_o  (active),
    .final_o   (final_byte)
  );

  rxo_byte_packer #(.DATA_W(DATA_W), .BYTE_W(BYTE_W), .BV_W(BV_W)) u_pack (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .take_i       (take),
    .byte_i       (rx_byte_i),
    .flush_i      (final_byte),
    .word_vld_o   (word_vld),
    .word_o       (word),
    .word_bytes_o (word_bytes),
    .word_last_o  (word_last)
  );

  rxo_push_stage #(.DATA_W(DATA_W), .BV_W(BV_W)) u_push (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .word_vld_i   (word_vld),
    .word_i       (word),
    .word_bytes_i (word_bytes),
    .word_last_i  (word_last),
    .fifo_full_i  (fifo_full_i),
    .fifo_wr_o    (fifo_wr_o),
    .fifo_wdata_o (fifo_wdata_o),
    .bval_o       (bval_o),
    .done_o       (done_o),
    .pend_o       (pend)
  );
endmodule

// File: rtl/rxo_recv_ctrl_chk.sv
module rxo_recv_ctrl_chk #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned BV_W   = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_wr_i,
  input logic [CNT_W-1:0]  req_cnt_i,
  input logic [CNT_W-1:0]  todo_o,
  input logic [BV_W-1:0]   bval_o,
  input logic              sclk_en_o,
  input logic              rx_vld_i,
  input logic              fifo_full_i,
  input logic              fifo_wr_o,
  input logic              done_o
);
  localparam int unsigned BPW = DATA_W / BYTE_W;

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_wr_o |-> !fifo_full_i); // R7
  AST_PAUSE_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_full_i |-> !sclk_en_o); // R7
  AST_IDLE_NO_CLK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (todo_o == '0) |-> !sclk_en_o); // R2
  AST_TODO_DEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_vld_i && (todo_o != '0) && !req_wr_i) |=> (todo_o == $past(todo_o) - CNT_W'(1))); // R3
  AST_REQ_ADD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_wr_i && !(rx_vld_i && (todo_o != '0)) &&
     (({1'b0, todo_o} + {1'b0, req_cnt_i}) <= {1'b0, {CNT_W{1'b1}}}))
    |=> (todo_o == $past(todo_o) + $past(req_cnt_i))); // R9
  AST_ZERO_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_wr_i && (req_cnt_i == '0) && !rx_vld_i) |=> $stable(todo_o)); // R10
  AST_BVAL_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_wr_o |-> ((bval_o != '0) && (bval_o <= BV_W'(BPW)))); // R6
  AST_DONE_WITH_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> fifo_wr_o); // R8
endmodule

bind rxo_recv_ctrl rxo_recv_ctrl_chk #(
  .DATA_W(DATA_W), .BYTE_W(BYTE_W), .CNT_W(CNT_W), .BV_W(BV_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_wr_i    (req_wr_i),
  .req_cnt_i   (req_cnt_i),
  .todo_o      (todo_o),
  .bval_o      (bval_o),
  .sclk_en_o   (sclk_en_o),
  .rx_vld_i    (rx_vld_i),
  .fifo_full_i (fifo_full_i),
  .fifo_wr_o   (fifo_wr_o),
  .done_o      (done_o)
);

// File: tb/rxo_recv_ctrl_bench.sv
`timescale 1ns/1ps
module rxo_recv_ctrl_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_wr_i = 1'b0;
  logic [15:0] req_cnt_i = '0;
  logic [15:0] todo_o;
  logic [2:0]  bval_o;
  logic        sclk_en_o;
  logic        rx_vld_i = 1'b0;
  logic [7:0]  rx_byte_i = '0;
  logic        fifo_full_i = 1'b0;
  logic        fifo_wr_o;
  logic [31:0] fifo_wdata_o;
  logic        done_o;

  int checks = 0;
  int errors = 0;

  int          exp_todo;
  logic [31:0] m_acc;
  int          m_fill;
  logic [31:0] q_data[$];
  int          q_bytes[$];
  bit          q_last[$];

  always #2 clk_i = ~clk_i;

  rxo_recv_ctrl u_rxo_recv_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_wr_i(req_wr_i), .req_cnt_i(req_cnt_i),
    .todo_o(todo_o), .bval_o(bval_o), .sclk_en_o(sclk_en_o), .rx_vld_i(rx_vld_i),
    .rx_byte_i(rx_byte_i), .fifo_full_i(fifo_full_i), .fifo_wr_o(fifo_wr_o),
    .fifo_wdata_o(fifo_wdata_o), .done_o(done_o)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic model_clear();
    exp_todo = 0; m_acc = '0; m_fill = 0;
    q_data.delete(); q_bytes.delete(); q_last.delete();
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0; req_wr_i = 0; rx_vld_i = 0; fifo_full_i = 0;
    model_clear();
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state
    chk(todo_o == 0, "R1 todo", 32'(todo_o), 0);
    chk(bval_o == 0, "R1 bval", 32'(bval_o), 0);
    chk(!sclk_en_o && !fifo_wr_o && !done_o, "R1 strobes",
        {29'd0, sclk_en_o, fifo_wr_o, done_o}, 0);
  endtask

  // one cycle: check, then drive inputs for the coming edge and advance the model
  task automatic step(input bit req, input logic [15:0] cnt, input int full_pct,
                      input int vld_pct, input bit force_vld);
    bit tk, fin, vld;
    logic [7:0] b;
    int nt;
    @(negedge clk_i);
    chk(todo_o == 16'(exp_todo), "R3/R9 todo", 32'(todo_o), 32'(exp_todo));
    fifo_full_i = ($urandom_range(99) < full_pct);
    req_wr_i = 1'b0; rx_vld_i = 1'b0;
    #1;
    chk(sclk_en_o == ((exp_todo != 0) && !fifo_full_i), "R2/R7 sclk",
        32'(sclk_en_o), 32'((exp_todo != 0) && !fifo_full_i));
    if (fifo_full_i) chk(!fifo_wr_o, "R7 write while full", 32'(fifo_wr_o), 0);
    if (fifo_wr_o) begin
      if (q_data.size() == 0) chk(0, "R3 unexpected write", fifo_wdata_o, 0);
      else begin
        chk(fifo_wdata_o == q_data[0], (q_bytes[0] == 4) ? "R4 data" : "R5 data",
            fifo_wdata_o, q_data[0]);
        chk(bval_o == 3'(q_bytes[0]), "R6 bval", 32'(bval_o), 32'(q_bytes[0]));
        chk(done_o == q_last[0], "R8 done", 32'(done_o), 32'(q_last[0]));
        void'(q_data.pop_front()); void'(q_bytes.pop_front()); void'(q_last.pop_front());
      end
    end else chk(!done_o, "R8 done without write", 32'(done_o), 0);
    b = 8'($urandom);
    vld = force_vld || (sclk_en_o && ($urandom_range(99) < vld_pct));
    rx_vld_i = vld; rx_byte_i = b; req_wr_i = req; req_cnt_i = cnt;
    tk  = vld && (exp_todo != 0);
    fin = tk && (exp_todo == 1) && !(req && cnt != 0);
    if (tk) begin
      m_acc = {m_acc[23:0], b};
      m_fill++;
      if (m_fill == 4 || fin) begin
        q_data.push_back(m_acc); q_bytes.push_back(m_fill); q_last.push_back(fin);
        m_acc = '0; m_fill = 0;
      end
    end
    nt = exp_todo + (req ? int'(cnt) : 0) - (tk ? 1 : 0);
    exp_todo = (nt > 65535) ? 65535 : nt;
  endtask

  task automatic drain();
    for (int i = 0; i < 400 && (exp_todo != 0 || q_data.size() != 0); i++) step(0, 0, 0, 100, 0);
    chk(q_data.size() == 0, "R7 entries lost", 32'(q_data.size()), 0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    do_reset();
    // R3: bytes offered while idle are ignored
    repeat (3) step(0, 0, 0, 0, 1);
    // R10: zero-count request
    step(1, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0);
    // R4/R5: 5 bytes -> full word then one-byte partial
    step(1, 16'd5, 0, 0, 0);
    drain();
    // R5/R7: 7 bytes under back-pressure
    step(1, 16'd7, 0, 0, 0);
    for (int i = 0; i < 60; i++) step(0, 0, 50, 100, 0);
    drain();
    // R9: add while active, R10 zero while active
    step(1, 16'd6, 0, 0, 0);
    step(0, 0, 0, 100, 0);
    step(1, 16'd3, 0, 0, 0);
    step(1, 16'd0, 0, 0, 0);
    drain();
    // random mix
    for (int i = 0; i < 4000; i++) begin
      bit r = ($urandom_range(99) < 6);
      step(r, 16'($urandom_range(12)), 25, 70, 0);
    end
    drain();
    // R9: saturation
    step(1, 16'hFFFF, 0, 0, 0);
    step(1, 16'd10, 100, 0, 0);
    step(0, 0, 100, 0, 0);
    chk(todo_o == 16'hFFFF, "R9 saturation", 32'(todo_o), 32'hFFFF);
    do_reset();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule